// File: doc/BRIEF.md
# Indexed Block Register Slave for a Two-Wire Serial Bus

This block lets a host on a two-wire serial bus (SMBus/I2C style) read and write a bank of sixteen 8-bit configuration registers. The block is a bus target only. The chip's bus pads supply the clock and data lines already synchronized to the system clock. The block pulls the data line low through an open-drain enable. All register contents are also presented in parallel so that the rest of the chip can use them directly.

Every write transaction has this sequence:

1. The target address with the write direction bit.
2. A starting index.
3. A byte count.
4. The data bytes.

A read transaction first writes the index. The host then issues a repeated start and sends the address with the read direction bit. The block answers with a byte count, which it takes from a writable register, and then streams registers from the index onward. It continues for as long as the host acknowledges.

The 7-bit target address comes from a strap input. The block captures the strap once, when reset ends. One register carries a two-bit output slew-rate field whose remaining bits are fixed. Two registers at the top of the bank hold read-only identification values.

Top module: `cfg_smbus_slave`

## Requirements
- R1: In a write transaction (start, address+W, index, count X, data bytes, stop) the block acknowledges the address, index and count bytes and each of the first X data bytes. Each of those data bytes lands in register index, index+1, and so on.
- R2: Data bytes beyond the count X are not acknowledged and are not written. The block then releases the data line until the next start or stop.
- R3: After the index is written, a repeated start followed by address+R makes the block send the value of register 8 first. It then sends the registers from the index onward and keeps going while the host acknowledges. A host NACK ends the transfer with the data line released.
- R4: The index uses only the low four bits of the index byte. The pointer advances by one after each written or sent data byte, and it wraps from 15 to 0.
- R5: A byte whose upper seven address bits differ from the captured address is not acknowledged. The block then leaves the data line released for every following clock until a new start.
- R6: The address is captured from the strap input on the first clock after reset is released. Later changes of the strap have no effect until the next reset.
- R7: Register 3 stores only bits 7:6 of a written value, and its bits 5:0 always read 0x1F. Registers 14 and 15 read 0xA5 and 0xA6. Writes to them are acknowledged and change nothing.
- R8: A stop, or a start, that arrives in the middle of a byte abandons that byte. Data bytes that were completely received and acknowledged before it remain written.
- R9: The block changes its data-line drive only while the serial clock is low.
- R10: After reset, register 3 reads 0x1F, register 8 reads 0x10, registers 14 and 15 read their fixed values, and all other registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line (bus level) |
| addr_strap | input | 7 | Target address strap, captured after reset |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| regs_o | output | 128 | All registers in parallel, register i at bits 8i+7:8i |

## Verification
Three events can land in the same clock cycle and must not corrupt each other:

- the clock fall that commits a received data byte, which writes the register and advances the pointer;
- the clock fall that ends an acknowledge and loads the next byte to send, which reads a register and advances the pointer;
- a start or stop that aborts the byte in progress.

The bench provokes these overlaps with several kinds of stimulus:

- Directed transactions stop or restart in the middle of a byte right after a committed byte.
- Index values force the pointer across the 15-to-0 wrap during both writes and reads.
- Random writes and reads are interleaved so that a read follows a write that has just changed register 8 or the registers being streamed.

Each outcome is judged at the ports. The bench compares the parallel register image and every received byte against a bench model of the bank, and it checks each acknowledge bit the host sees.

// File: rtl/smbs_pkg.sv
package smbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_TX,
    ST_TX,
    ST_ACK_RX,
    ST_IGNORE
  } smb_state_e;

  typedef enum logic [2:0] {
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_WDATA,
    PH_READ
  } smb_phase_e;

endpackage

// File: rtl/smbs_line_mon.sv
module smbs_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/smbs_regfile.sv
module smbs_regfile #(
  parameter int          NREG     = 16,
  parameter int          DW       = 8,
  parameter int          RO_FIRST = 14,
  parameter int          SLEW_IDX = 3,
  parameter int          CNT_IDX  = 8,
  parameter logic [7:0]  CNT_RST  = 8'h10,
  parameter logic [7:0]  RO_BASE  = 8'hA5,
  localparam int         IW       = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_data,
  output logic [NREG*DW-1:0] regs_o
);

  localparam logic [DW-3:0] SLEW_FIX = (DW-2)'(6'h1F);

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == IW'(gi));

    if (gi >= RO_FIRST) begin : g_ro
      assign regs_o[gi*DW +: DW] = DW'(RO_BASE) + DW'(gi - RO_FIRST);
    end else if (gi == SLEW_IDX) begin : g_slew
      logic [1:0] slew_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   slew_q <= 2'b00;
        else if (hit) slew_q <= wr_data[DW-1:DW-2];
      end
      assign regs_o[gi*DW +: DW] = {slew_q, SLEW_FIX};
    end else begin : g_rw
      localparam logic [DW-1:0] RST_V = (gi == CNT_IDX) ? DW'(CNT_RST) : '0;
      logic [DW-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   val_q <= RST_V;
        else if (hit) val_q <= wr_data;
      end
      assign regs_o[gi*DW +: DW] = val_q;
    end
  end

endmodule

// File: rtl/smbs_engine.sv
module smbs_engine
  import smbs_pkg::*;
#(
  parameter int  NREG = 16,
  parameter int  DW   = 8,
  parameter int  AW   = 7,
  localparam int IW   = $clog2(NREG),
  localparam int CW   = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic [AW-1:0] dev_addr,
  input  logic [DW-1:0] rd_data,
  input  logic [DW-1:0] cnt_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic [IW-1:0] ptr,
  output logic [DW-1:0] wrem,
  output smb_state_e    state
);

  smb_state_e    st_q, st_d;
  smb_phase_e    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [IW-1:0] ptr_q, ptr_d;
  logic [DW-1:0] wrem_q, wrem_d;
  logic          oe_q, oe_d;
  logic          hack_q, hack_d;
  logic          first_q, first_d;
  logic          ack, load;
  logic [DW-1:0] tx_byte;

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    wrem_d  = wrem_q;
    oe_d    = oe_q;
    hack_d  = hack_q;
    first_d = first_q;
    wr_en   = 1'b0;
    ack     = 1'b0;
    load    = 1'b0;
    tx_byte = first_q ? cnt_data : rd_data;

    if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (start_det) begin
      st_d  = ST_RX;
      ph_d  = PH_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise && cnt_q != CW'(DW)) begin
            sh_d  = {sh_q[DW-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CW'(DW)) begin
            case (ph_q)
              PH_ADDR: begin
                if (sh_q[DW-1:1] == dev_addr) begin
                  ack = 1'b1;
                  if (sh_q[0]) begin
                    ph_d    = PH_READ;
                    first_d = 1'b1;
                  end else begin
                    ph_d = PH_INDEX;
                  end
                end
              end
              PH_INDEX: begin
                ack   = 1'b1;
                ptr_d = sh_q[IW-1:0];
                ph_d  = PH_COUNT;
              end
              PH_COUNT: begin
                ack    = 1'b1;
                wrem_d = sh_q;
                ph_d   = PH_WDATA;
              end
              PH_WDATA: begin
                if (wrem_q != '0) begin
                  ack    = 1'b1;
                  wr_en  = 1'b1;
                  ptr_d  = ptr_q + 1'b1;
                  wrem_d = wrem_q - 1'b1;
                end
              end
              default: ;
            endcase
            if (ack) begin
              st_d = ST_ACK_TX;
              oe_d = 1'b1;
            end else begin
              st_d = ST_IGNORE;
              oe_d = 1'b0;
            end
          end
        end
        ST_ACK_TX: begin
          if (scl_fall) begin
            if (ph_q == PH_READ) begin
              load = 1'b1;
            end else begin
              st_d  = ST_RX;
              cnt_d = '0;
              oe_d  = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CW'(DW - 1)) begin
              st_d = ST_ACK_RX;
              oe_d = 1'b0;
            end else begin
              sh_d  = {sh_q[DW-2:0], 1'b0};
              oe_d  = ~sh_q[DW-2];
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_ACK_RX: begin
          if (scl_rise) hack_d = ~sda_s;
          if (scl_fall) begin
            if (hack_q) load = 1'b1;
            else        st_d = ST_IGNORE;
          end
        end
        default: ;
      endcase

      if (load) begin
        st_d    = ST_TX;
        sh_d    = tx_byte;
        oe_d    = ~tx_byte[DW-1];
        cnt_d   = '0;
        first_d = 1'b0;
        if (!first_q) ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ph_q    <= PH_ADDR;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      wrem_q  <= '0;
      oe_q    <= 1'b0;
      hack_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      wrem_q  <= wrem_d;
      oe_q    <= oe_d;
      hack_q  <= hack_d;
      first_q <= first_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_idx  = ptr_q;
  assign wr_data = sh_q;
  assign ptr     = ptr_q;
  assign wrem    = wrem_q;
  assign state   = st_q;

endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave
  import smbs_pkg::*;
#(
  parameter int  NREG     = 16,
  parameter int  DW       = 8,
  parameter int  AW       = 7,
  parameter int  CNT_IDX  = 8,
  parameter int  RO_FIRST = 14,
  localparam int IW       = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [AW-1:0]      addr_strap,
  output logic               sda_oe,
  output logic [NREG*DW-1:0] regs_o
);

  logic          rst_meta, rst_s;
  logic          strap_done;
  logic [AW-1:0] dev_addr;
  logic          scl_rise, scl_fall, start_det, stop_det;
  logic          wr_en;
  logic [IW-1:0] wr_idx, ptr;
  logic [DW-1:0] wr_data, wrem;
  smb_state_e    eng_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      strap_done <= 1'b0;
      dev_addr   <= '0;
    end else if (!strap_done) begin
      strap_done <= 1'b1;
      dev_addr   <= addr_strap;
    end
  end

  smbs_line_mon u_mon (
    .clk       (clk),
    .rst_n     (rst_s),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smbs_engine #(.NREG(NREG), .DW(DW), .AW(AW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_i),
    .dev_addr  (dev_addr),
    .rd_data   (regs_o[ptr*DW +: DW]),
    .cnt_data  (regs_o[CNT_IDX*DW +: DW]),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .ptr       (ptr),
    .wrem      (wrem),
    .state     (eng_state)
  );

  smbs_regfile #(.NREG(NREG), .DW(DW), .RO_FIRST(RO_FIRST), .CNT_IDX(CNT_IDX)) u_rf (
    .clk     (clk),
    .rst_n   (rst_s),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .regs_o  (regs_o)
  );

endmodule

// File: rtl/smbs_checker.sv
module smbs_checker
  import smbs_pkg::*;
#(
  parameter int  NREG     = 16,
  parameter int  DW       = 8,
  parameter int  AW       = 7,
  parameter int  RO_FIRST = 14,
  localparam int IW       = $clog2(NREG)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_i,
  input logic               sda_oe,
  input logic [2:0]         state,
  input logic               strap_done,
  input logic [AW-1:0]      dev_addr,
  input logic               wr_en,
  input logic [IW-1:0]      wr_idx,
  input logic [IW-1:0]      ptr,
  input logic [DW-1:0]      wrem,
  input logic [NREG*DW-1:0] regs_o
);

  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_i)); // R9

  AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'(ST_IGNORE)) |-> !sda_oe); // R5

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && $past(strap_done)) |-> $stable(dev_addr)); // R6

  AST_RO_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx >= IW'(RO_FIRST))) |=> $stable(regs_o[NREG*DW-1:RO_FIRST*DW])); // R7

  AST_WRITE_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wrem != '0)); // R2

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == $past(ptr) + 1'b1)); // R4

endmodule

bind cfg_smbus_slave smbs_checker #(.NREG(NREG), .DW(DW), .AW(AW), .RO_FIRST(RO_FIRST)) i_chk (
  .clk        (clk),
  .rst_n      (rst_s),
  .scl_i      (scl_i),
  .sda_oe     (sda_oe),
  .state      (eng_state),
  .strap_done (strap_done),
  .dev_addr   (dev_addr),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .ptr        (ptr),
  .wrem       (wrem),
  .regs_o     (regs_o)
);

// File: tb/test_cfg_smbus_slave.sv
module test_cfg_smbus_slave;

  localparam logic [6:0] STRAP = 7'h6A;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         scl = 1'b1;
  logic         sda_h = 1'b1;
  logic [6:0]   strap = STRAP;
  logic         sda_oe;
  logic [127:0] regs_o;
  logic         sda_bus;

  int checks = 0;
  int errors = 0;
  int r9_bad = 0;
  int oe_cycles = 0;
  logic prev_oe = 1'b0;
  logic [7:0] exp_r [16];
  logic [7:0] dbuf [8];

  assign sda_bus = sda_h & ~sda_oe;

  cfg_smbus_slave i_cfg_smbus_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_bus),
    .addr_strap (strap),
    .sda_oe     (sda_oe),
    .regs_o     (regs_o)
  );

  always #10 clk = ~clk;

  // R9 monitor: a drive change must be computed from a low clock level
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (sda_oe !== prev_oe && scl !== 1'b0) r9_bad++;
      if (sda_oe) oe_cycles++;
    end
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] apply_wr(input int idx, input logic [7:0] old, input logic [7:0] d);
    if (idx >= 14)     return old;
    else if (idx == 3) return {d[7:6], 6'h1F};
    else               return d;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) exp_r[i] = 8'h00;
    exp_r[3]  = 8'h1F;
    exp_r[8]  = 8'h10;
    exp_r[14] = 8'hA5;
    exp_r[15] = 8'hA6;
  endtask

  task automatic cmp_regs(input string req);
    for (int i = 0; i < 16; i++)
      chk(regs_o[i*8 +: 8] === exp_r[i], req, $sformatf("reg%0d", i), int'(regs_o[i*8 +: 8]), int'(exp_r[i]));
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic gap();
    repeat (2) @(negedge clk);
  endtask

  task automatic do_start();
    sda_h = 1'b1; half(); scl = 1'b1; half(); sda_h = 1'b0; half(); scl = 1'b0; gap();
  endtask

  task automatic do_stop();
    sda_h = 1'b0; half(); scl = 1'b1; half(); sda_h = 1'b1; half();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_h = b[i]; half(); scl = 1'b1; half(); scl = 1'b0; gap();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_h = 1'b1; half(); scl = 1'b1;
    repeat (4) @(negedge clk);
    ack = (sda_bus == 1'b0);
    repeat (4) @(negedge clk);
    scl = 1'b0; gap();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_h = 1'b1;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      half(); scl = 1'b1;
      repeat (4) @(negedge clk);
      b = {b[6:0], sda_bus};
      repeat (4) @(negedge clk);
      scl = 1'b0;
    end
    gap();
    sda_h = give_ack ? 1'b0 : 1'b1;
    half(); scl = 1'b1; half(); scl = 1'b0; gap();
    sda_h = 1'b1;
  endtask

  // full write: idxb is the raw index byte, nb data bytes from dbuf
  task automatic do_write(input logic [7:0] idxb, input logic [7:0] cnt, input int nb, input string req);
    bit a;
    int p;
    do_start();
    send_byte({STRAP, 1'b0}, a);
    chk(a, "R1", "address ack", int'(a), 1);
    send_byte(idxb, a);
    chk(a, "R1", "index ack", int'(a), 1);
    send_byte(cnt, a);
    chk(a, "R1", "count ack", int'(a), 1);
    p = int'(idxb[3:0]);
    for (int i = 0; i < nb; i++) begin
      send_byte(dbuf[i], a);
      if (i < int'(cnt)) begin
        chk(a, req, "data ack", int'(a), 1);
        exp_r[p] = apply_wr(p, exp_r[p], dbuf[i]);
        p = (p + 1) % 16;
      end else begin
        chk(!a, "R2", "data beyond count nacked", int'(a), 0);
        break;
      end
    end
    do_stop();
    cmp_regs(req);
  endtask

  task automatic do_read(input int idx, input int nb, input string req);
    bit a;
    logic [7:0] b;
    do_start();
    send_byte({STRAP, 1'b0}, a);
    send_byte(8'(idx), a);
    do_start();
    send_byte({STRAP, 1'b1}, a);
    chk(a, "R3", "read address ack", int'(a), 1);
    recv_byte(1'b1, b);
    chk(b === exp_r[8], "R3", "read count byte", int'(b), int'(exp_r[8]));
    for (int i = 0; i < nb; i++) begin
      recv_byte(i != nb - 1, b);
      chk(b === exp_r[(idx + i) % 16], req, $sformatf("read data %0d", i), int'(b), int'(exp_r[(idx + i) % 16]));
    end
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R3", "released after NACK", int'(sda_oe), 0);
    do_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not complete actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit a;
    int unsigned seed;
    seed = 32'h5EED1234;
    void'($urandom(seed));
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R10 reset image
    cmp_regs("R10");
    chk(sda_oe == 1'b0, "R10", "released after reset", int'(sda_oe), 0);

    // R6 strap changes after reset are ignored
    strap = 7'h15;
    do_start(); send_byte({7'h15, 1'b0}, a); do_stop();
    chk(!a, "R6", "new strap value not answered", int'(a), 0);

    // R1 basic write
    dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33;
    do_write(8'h02, 8'd3, 3, "R1");

    // R2 extra byte nacked and not written
    dbuf[0] = 8'h44; dbuf[1] = 8'h55; dbuf[2] = 8'h66;
    do_write(8'h0A, 8'd2, 3, "R2");
    dbuf[0] = 8'h77;
    do_write(8'h05, 8'd0, 1, "R2");

    // R4 wrap and upper index bits ignored, R7 read-only and slew field
    dbuf[0] = 8'h01; dbuf[1] = 8'h02; dbuf[2] = 8'h03; dbuf[3] = 8'h04;
    do_write(8'hEE, 8'd4, 4, "R4");
    dbuf[0] = 8'hC0;
    do_write(8'h33, 8'd1, 1, "R7");
    chk(regs_o[31:24] === 8'hDF, "R7", "slew register", int'(regs_o[31:24]), 8'hDF);

    // R3 read with count from register 8, past the count and across the wrap
    dbuf[0] = 8'h04;
    do_write(8'h08, 8'd1, 1, "R3");
    do_read(13, 6, "R3");
    do_read(0, 2, "R4");

    // R5 mismatched address: no ack and no drive at all until stop
    oe_cycles = 0;
    do_start();
    send_byte({7'h6B, 1'b0}, a);
    chk(!a, "R5", "mismatch nack", int'(a), 0);
    send_byte(8'h01, a);
    send_byte(8'h01, a);
    send_byte(8'h99, a);
    do_stop();
    chk(oe_cycles == 0, "R5", "no drive after mismatch", oe_cycles, 0);
    cmp_regs("R5");

    // R8 stop in mid byte
    do_start();
    send_byte({STRAP, 1'b0}, a);
    send_byte(8'h06, a);
    send_byte(8'h04, a);
    send_byte(8'hA1, a);
    chk(a, "R8", "first data ack", int'(a), 1);
    exp_r[6] = 8'hA1;
    send_bits(8'hFF, 3);
    do_stop();
    cmp_regs("R8");

    // R8 start in mid byte, then a fresh transaction works
    do_start();
    send_byte({STRAP, 1'b0}, a);
    send_byte(8'h09, a);
    send_byte(8'h02, a);
    send_byte(8'h5A, a);
    exp_r[9] = 8'h5A;
    send_bits(8'h3C, 4);
    do_start();
    send_byte({STRAP, 1'b0}, a);
    chk(a, "R8", "address after restart", int'(a), 1);
    do_stop();
    cmp_regs("R8");

    // random mix
    for (int t = 0; t < 20; t++) begin
      int idx;
      int cnt;
      int nb;
      idx = int'($urandom_range(0, 15));
      cnt = int'($urandom_range(0, 4));
      nb  = cnt + int'($urandom_range(0, 1));
      for (int i = 0; i < 8; i++) dbuf[i] = 8'($urandom);
      if (idx == 8) dbuf[0] = 8'($urandom_range(0, 5));
      do_write(8'(($urandom & 32'hF0) | 32'(idx)), 8'(cnt), nb, "R1");
      if ($urandom_range(0, 1) == 1) do_read(int'($urandom_range(0, 15)), int'($urandom_range(1, 4)), "R3");
    end

    chk(r9_bad == 0, "R9", "drive changes while clock high", r9_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule